// File: doc/BRIEF.md
# Computed AES Byte Substitution Unit

This block performs the AES byte substitution on one byte per clock. It does not read the result from a stored table. The forward result is built in two steps: the byte's multiplicative inverse in GF(2^8), then an affine map over GF(2). The inverse result runs the same two steps in the opposite order, with the inverse affine map applied first. One field inverter serves both directions. The inverter raises the operand to the 254th power using a chain of squarers and multipliers.

A caller presents a byte, a direction select and a valid strobe. On the next clock edge the unit captures the substituted byte into its output register and raises its output-valid flag for one cycle. While no valid input is offered, the output register keeps its last result. Because each byte is processed independently, several instances can sit side by side across a cipher state.

Top module: `sbox_top`

## Requirements
- R1: While reset (rstN low) is asserted and after it is released with no valid input, outValid is 0 and outByte is 8'h00.
- R2: With decrypt = 0, the result is the affine map applied to the GF(2^8) inverse of inByte, where the inverse uses reduction polynomial x^8+x^4+x^3+x+1 (0x11B). Output bit i of the affine map is b[i]^b[(i+4)%8]^b[(i+5)%8]^b[(i+6)%8]^b[(i+7)%8]^c[i], with c = 8'h63.
- R3: Input 8'h00 has no field inverse and is treated as 8'h00 before the affine step, so the forward result for 8'h00 is 8'h63.
- R4: With decrypt = 1, the unit first applies the inverse affine map and then the field inverse. Output bit i of the inverse affine map is b[(i+2)%8]^b[(i+5)%8]^b[(i+7)%8]^d[i], with d = 8'h05. As a consequence, input 8'h63 yields 8'h00.
- R5: Feeding any forward result back in with decrypt = 1 returns the original byte, for all 256 inputs.
- R6: outValid is 1 exactly in the cycle after a cycle with inValid = 1, and outByte carries that input's result in the same cycle.
- R7: In the cycle after inValid = 0, outValid is 0 and outByte is unchanged, whatever the values of inByte and decrypt.
- R8: The forward result for 8'h53 is 8'hED.
- R9: Across all 256 inputs, the forward results are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte is valid this cycle |
| decrypt | input | 1 | 0 selects the forward substitution, 1 the inverse |
| inByte | input | 8 | Byte to substitute |
| outValid | output | 1 | Result registered from the previous cycle's valid input |
| outByte | output | 8 | Substituted byte |

## Verification
Every result is due exactly one rising edge after the cycle in which its byte is presented. The bench drives inputs on the falling edge and reads outByte and outValid on the next falling edge, so each read lands half a period after the capturing edge. For the hold check, the bench drives idle cycles with a changed inByte and decrypt and reads the outputs one falling edge later. For the round trip, the bench feeds a forward result back in with decrypt = 1 and reads the answer on the following falling edge.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic capture;
    logic inverse;
  } strobe_t;

  // Carry-less multiply with modular reduction; polyLow is the polynomial without its x^8 term
  function automatic byte_t gfMul(input byte_t a, input byte_t b, input byte_t polyLow);
    byte_t acc;
    byte_t sh;
    logic  carry;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      carry = sh[BYTE_W-1];
      sh    = sh << 1;
      if (carry) sh = sh ^ polyLow;
    end
    return acc;
  endfunction
endpackage

// File: rtl/sbox_gf_inv.sv
module sbox_gf_inv
  import sbox_pkg::*;
#(
  parameter byte_t POLY_LOW = 8'h1B
) (
  input  byte_t operand,
  output byte_t inverse
);
  localparam int STEPS = BYTE_W - 1;

  // sq[k] = operand^(2^k); power 254 = product of sq[1..7]; zero stays zero
  byte_t sq   [0:STEPS];
  byte_t prod [1:STEPS];

  assign sq[0] = operand;

  genvar k;
  generate
    for (k = 1; k <= STEPS; k++) begin : g_square
      assign sq[k] = gfMul(sq[k-1], sq[k-1], POLY_LOW);
    end
    assign prod[1] = sq[1];
    for (k = 2; k <= STEPS; k++) begin : g_product
      assign prod[k] = gfMul(prod[k-1], sq[k], POLY_LOW);
    end
  endgenerate

  assign inverse = prod[STEPS];
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
  import sbox_pkg::*;
#(
  parameter bit    INVERSE = 1'b0,
  parameter byte_t CONST   = 8'h63
) (
  input  byte_t din,
  output byte_t dout
);
  genvar i;
  generate
    if (INVERSE) begin : g_rev
      for (i = 0; i < BYTE_W; i++) begin : g_bit
        assign dout[i] = din[(i+2)%BYTE_W] ^ din[(i+5)%BYTE_W]
                       ^ din[(i+7)%BYTE_W] ^ CONST[i];
      end
    end else begin : g_fwd
      for (i = 0; i < BYTE_W; i++) begin : g_bit
        assign dout[i] = din[i] ^ din[(i+4)%BYTE_W] ^ din[(i+5)%BYTE_W]
                       ^ din[(i+6)%BYTE_W] ^ din[(i+7)%BYTE_W] ^ CONST[i];
      end
    end
  endgenerate
endmodule

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    decrypt,
  output strobe_t strobe,
  output logic    outValid
);
  always_comb begin
    strobe.capture = inValid;
    strobe.inverse = decrypt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/sbox_dpath.sv
module sbox_dpath
  import sbox_pkg::*;
#(
  parameter byte_t POLY_LOW  = 8'h1B,
  parameter byte_t FWD_CONST = 8'h63,
  parameter byte_t INV_CONST = 8'h05
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  byte_t   inByte,
  output byte_t   outByte
);
  byte_t unmapped;
  byte_t invIn;
  byte_t invOut;
  byte_t mapped;
  byte_t result;

  // Inverse direction: undo the affine map before the shared inverter
  sbox_affine #(.INVERSE(1'b1), .CONST(INV_CONST)) uInvAff (
    .din (inByte),
    .dout(unmapped)
  );

  assign invIn = strobe.inverse ? unmapped : inByte;

  sbox_gf_inv #(.POLY_LOW(POLY_LOW)) uInv (
    .operand(invIn),
    .inverse(invOut)
  );

  // Forward direction: affine map after the inverter
  sbox_affine #(.INVERSE(1'b0), .CONST(FWD_CONST)) uFwdAff (
    .din (invOut),
    .dout(mapped)
  );

  assign result = strobe.inverse ? invOut : mapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outByte <= '0;
    else if (strobe.capture) outByte <= result;
  end
endmodule

// File: rtl/sbox_top.sv
module sbox_top
  import sbox_pkg::*;
#(
  parameter byte_t POLY_LOW  = 8'h1B,
  parameter byte_t FWD_CONST = 8'h63,
  parameter byte_t INV_CONST = 8'h05
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       decrypt,
  input  logic [7:0] inByte,
  output logic       outValid,
  output logic [7:0] outByte
);
  strobe_t strobe;

  sbox_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .decrypt (decrypt),
    .strobe  (strobe),
    .outValid(outValid)
  );

  sbox_dpath #(
    .POLY_LOW (POLY_LOW),
    .FWD_CONST(FWD_CONST),
    .INV_CONST(INV_CONST)
  ) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inByte (inByte),
    .outByte(outByte)
  );
endmodule

// File: rtl/sbox_checker.sv
module sbox_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       decrypt,
  input logic [7:0] inByte,
  input logic       outValid,
  input logic [7:0] outByte
);
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_no_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outByte));

  p_zero_fwd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !decrypt && inByte == 8'h00) |=> (outByte == 8'h63));

  p_zero_back_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && decrypt && inByte == 8'h63) |=> (outByte == 8'h00));

  p_spot_fwd_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !decrypt && inByte == 8'h53) |=> (outByte == 8'hED));
endmodule

bind sbox_top sbox_checker uChk (.*);

// File: tb/tb_sbox_top.sv
module tb_sbox_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       decrypt = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       outValid;
  logic [7:0] outByte;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] fwdSeen [0:255];
  logic [255:0] hit;

  always #2.5 clk = ~clk;

  sbox_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .decrypt(decrypt),
    .inByte(inByte), .outValid(outValid), .outByte(outByte)
  );

  function automatic logic [7:0] mMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int j = 15; j >= 8; j--) if (p[j]) p = p ^ (16'h011B << (j - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] mInv(input logic [7:0] a);
    logic [7:0] r = 8'h00;
    for (int y = 1; y < 256; y++) if (mMul(a, 8'(y)) == 8'h01) r = 8'(y);
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] mFwd(input logic [7:0] x);
    logic [7:0] b = mInv(x);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] mBack(input logic [7:0] x);
    return mInv(rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ 8'h05);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Present one byte, read the result one edge later (R6)
  task automatic apply(input logic dec, input logic [7:0] x, output logic [7:0] res);
    @(negedge clk);
    inValid = 1'b1; decrypt = dec; inByte = x;
    @(negedge clk);
    inValid = 1'b0;
    check("R6 outValid", {7'b0, outValid}, 8'h01);
    res = outByte;
  endtask

  initial begin
    logic [7:0] r;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", {7'b0, outValid}, 8'h00);
    check("R1 outByte in reset", outByte, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", {7'b0, outValid}, 8'h00);
    check("R1 outByte after reset", outByte, 8'h00);

    apply(1'b0, 8'h00, r); check("R3 S(00)", r, 8'h63);
    apply(1'b0, 8'h53, r); check("R8 S(53)", r, 8'hED);
    apply(1'b1, 8'h63, r); check("R4 InvS(63)", r, 8'h00);

    hit = '0;
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, 8'(x), r);
      check("R2 forward", r, mFwd(8'(x)));
      fwdSeen[x] = r;
      checks++;
      if (hit[r]) begin
        errors++;
        $display("FAIL R9: actual=%02h repeated expected=distinct", r);
      end
      hit[r] = 1'b1;
    end

    for (int x = 0; x < 256; x++) begin
      apply(1'b1, 8'(x), r);
      check("R4 inverse", r, mBack(8'(x)));
    end

    for (int x = 0; x < 256; x++) begin
      apply(1'b1, fwdSeen[x], r);
      check("R5 round trip", r, 8'(x));
    end

    // R7: idle cycles with changing inputs leave the output untouched
    apply(1'b0, 8'h01, held);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      inValid = 1'b0; decrypt = k[0]; inByte = 8'(8'h5A + k);
      @(negedge clk);
      check("R7 outValid idle", {7'b0, outValid}, 8'h00);
      check("R7 outByte hold", outByte, held);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule